// File: doc/BRIEF.md
# Multi-Channel Selectable-Clock Match Timer

This block is a bank of eight compare timers, numbered 4 to 11. Each channel has a 32-bit counter, a 32-bit match register and a control register. A three-bit field in the control register picks which of five tick-enable inputs advances the channel. The field can also stop the channel. A channel either counts on its own or watches a group counter owned by a leading channel. Channels 4, 8 and 10 lead. Channel 4 leads 5, 6 and 7, channel 8 leads 9, and channel 10 leads 11. When the compared counter steps onto the match value, the channel raises its status bit, provided its enable bit is set.

When a match occurs, the counter can be cleared, and the channel can stay armed for later matches. Channels 9 and 11 can be configured so that reading their counter latches their leader's counter into a shared snapshot register. All status bits drive one combined interrupt. Software reaches everything through a single-cycle register port with a byte address. Reads return data in the same cycle, and writes take effect at the clock edge.

Top module: `tmx_match_timer`

## Requirements
- R1: After reset, every counter, match register, control register, status bit, enable bit and the snapshot read as zero, and `irq` is low.
- R2: Control bits [2:0] pick the count source: code k from 1 to 5 uses `tick_en[k-1]`, and codes 0, 6 and 7 stop the channel. A running counter gains one in each cycle its chosen tick is high, and a stopped counter holds its value.
- R3: On channels 8 to 11, control bit 8 set stops the channel whatever bits [2:0] hold.
- R4: A write to a counter in the same cycle as a tick loads the written value, and the tick is lost.
- R5: On channels 5, 6, 7, 9 and 11, control bit 7 clear makes the channel compare against its leader's counter, and its own counter holds. Channels 4, 8 and 10 always use their own counter.
- R6: A match occurs in the cycle the compared counter advances to a value equal to the armed match register. The match sets status bit 4+n only if enable bit 4+n is set, and a set status bit drives `irq` high.
- R7: With control bit 3 set, a matching channel's own counter loads zero instead of the matching value.
- R8: Writing the match register arms the channel. With control bit 6 clear, the first match disarms it. With bit 6 set, it stays armed and matches again each time the value recurs.
- R9: On channels 9 and 11 with control bit 9 set, reading the channel's counter copies counter 8 or counter 10 into the snapshot register at offset 0x20. Without bit 9, the snapshot is unchanged.
- R10: Control writes keep bits [7:0] on channels 4 to 7 and bits [9:0] on channels 8 to 11. Other bits read as zero.
- R11: Writing the status register at 0x14 with a one in bit 4+n clears that bit. `irq` stays high until all of bits 4 to 11 are clear.
- R12: Address map: counters at 0x40+4n, match registers at 0x80+4n and controls at 0xC0+4n, for channel index n = 0 to 7 (channel 4+n). Status is at 0x14, enable at 0x1C, and only bits 4 to 11 of each exist.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (needed for the snapshot side effect) |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| tick_en | input | 5 | Tick-enable sources for codes 1 to 5 |
| irq | output | 1 | Combined interrupt from status bits 4 to 11 |

## Verification
Counting is driven with tick masks that hit only the chosen source and with masks that hit every other source. This separates a correct source decode from an off-by-one selection. Matches are produced on a leader, on a follower tracking its leader, on a channel using its own counter, and with its enable bit clear. This separates the choice of compare source from the enable gating. Repeated match runs with bit 6 set and clear tell re-arming apart from one-shot behaviour. Staged status clears show that the interrupt waits for the last bit.

// File: rtl/tmx_pkg.sv
package tmx_pkg;
  localparam int NCH      = 8;
  localparam int FIRST_CH = 4;
  localparam int CW       = 32;
  localparam int AW       = 8;
  localparam int NTICK    = 5;
  localparam int CTLW     = 10;

  localparam int CB_RST   = 3;
  localparam int CB_PER   = 6;
  localparam int CB_OWN   = 7;
  localparam int CB_FSTOP = 8;
  localparam int CB_SNAP  = 9;

  localparam logic [AW-1:0] A_STAT = 8'h14;
  localparam logic [AW-1:0] A_IEN  = 8'h1C;
  localparam logic [AW-1:0] A_SNAP = 8'h20;
  localparam logic [2:0]    BLK_CNT = 3'b010;
  localparam logic [2:0]    BLK_MAT = 3'b100;
  localparam logic [2:0]    BLK_CTL = 3'b110;

  function automatic int leader_of(input int r);
    if (r < 4) return 0;
    else if (r < 6) return 4;
    else return 6;
  endfunction

  function automatic bit is_leader(input int r);
    return (r == 0) || (r == 4) || (r == 6);
  endfunction

  function automatic bit wide_ctrl(input int r);
    return r >= 4;
  endfunction

  function automatic bit snap_pair(input int r);
    return (r == 5) || (r == 7);
  endfunction
endpackage

// File: rtl/tmx_tick_sel.sv
module tmx_tick_sel
  import tmx_pkg::*;
#(
  parameter bit WIDE = 1'b0
) (
  input  logic [CTLW-1:0]  ctrl,
  input  logic [NTICK-1:0] ticks,
  output logic             tick
);
  logic [2:0] sel;

  always_comb begin
    sel = ctrl[2:0];
    if (WIDE && ctrl[CB_FSTOP]) sel = 3'd0;
  end

  always_comb begin
    tick = 1'b0;
    for (int k = 0; k < NTICK; k++) begin
      if (sel == 3'(k + 1)) tick = ticks[k];
    end
  end
endmodule

// File: rtl/tmx_channel.sv
module tmx_channel
  import tmx_pkg::*;
#(
  parameter bit LEADER = 1'b0,
  parameter bit WIDE   = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTICK-1:0] ticks,
  input  logic             we_match,
  input  logic             we_cnt,
  input  logic             we_ctrl,
  input  logic [CW-1:0]    wdata,
  input  logic             src_adv,
  input  logic [CW-1:0]    src_inc,
  output logic [CW-1:0]    cnt_q,
  output logic [CW-1:0]    cnt_inc,
  output logic             adv,
  output logic [CTLW-1:0]  ctrl_q,
  output logic             hit
);
  localparam logic [CTLW-1:0] CMASK = WIDE ? {CTLW{1'b1}} : CTLW'(8'hFF);

  logic [CW-1:0]   cnt_d, match_q, match_d;
  logic [CTLW-1:0] ctrl_d;
  logic            armed_q, armed_d;
  logic            tick, use_own, cmp_adv;
  logic [CW-1:0]   cmp_val;

  tmx_tick_sel #(.WIDE(WIDE)) u_sel (
    .ctrl  (ctrl_q),
    .ticks (ticks),
    .tick  (tick)
  );

  always_comb begin
    use_own = LEADER || ctrl_q[CB_OWN];
    adv     = use_own & tick;
    cnt_inc = cnt_q + 1'b1;
    cmp_adv = use_own ? adv : src_adv;
    cmp_val = use_own ? cnt_inc : src_inc;
    hit     = armed_q & cmp_adv & (cmp_val == match_q);
  end

  always_comb begin
    cnt_d   = cnt_q;
    if (we_cnt) cnt_d = wdata;
    else if (hit && ctrl_q[CB_RST]) cnt_d = '0;
    else if (adv) cnt_d = cnt_inc;
    ctrl_d  = we_ctrl ? (wdata[CTLW-1:0] & CMASK) : ctrl_q;
    match_d = we_match ? wdata : match_q;
    armed_d = armed_q;
    if (we_match) armed_d = 1'b1;
    else if (hit && !ctrl_q[CB_PER]) armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ctrl_q  <= '0;
      match_q <= '0;
      armed_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      ctrl_q  <= ctrl_d;
      match_q <= match_d;
      armed_q <= armed_d;
    end
  end
endmodule

// File: rtl/tmx_match_timer.sv
module tmx_match_timer
  import tmx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [AW-1:0]    bus_addr,
  input  logic [CW-1:0]    bus_wdata,
  output logic [CW-1:0]    bus_rdata,
  input  logic [NTICK-1:0] tick_en,
  output logic             irq
);
  localparam int IW = $clog2(NCH);

  logic [CW-1:0]   cnt_q   [NCH];
  logic [CW-1:0]   inc     [NCH];
  logic [CTLW-1:0] ctrl_q  [NCH];
  logic            adv     [NCH];
  logic [NCH-1:0]  hit;
  logic [NCH-1:0]  status_q, status_d, ien_q, ien_d, clr_mask;
  logic [CW-1:0]   snap_q, snap_d;
  logic [IW-1:0]   idx;
  logic            in_cnt, in_mat, in_ctl;

  assign idx    = bus_addr[IW+1:2];
  assign in_cnt = bus_addr[AW-1:AW-3] == BLK_CNT;
  assign in_mat = bus_addr[AW-1:AW-3] == BLK_MAT;
  assign in_ctl = bus_addr[AW-1:AW-3] == BLK_CTL;

  for (genvar r = 0; r < NCH; r++) begin : g_ch
    localparam int LR = leader_of(r);
    tmx_channel #(.LEADER(is_leader(r)), .WIDE(wide_ctrl(r))) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .ticks    (tick_en),
      .we_match (bus_wr && in_mat && idx == IW'(r)),
      .we_cnt   (bus_wr && in_cnt && idx == IW'(r)),
      .we_ctrl  (bus_wr && in_ctl && idx == IW'(r)),
      .wdata    (bus_wdata),
      .src_adv  (adv[LR]),
      .src_inc  (inc[LR]),
      .cnt_q    (cnt_q[r]),
      .cnt_inc  (inc[r]),
      .adv      (adv[r]),
      .ctrl_q   (ctrl_q[r]),
      .hit      (hit[r])
    );
  end

  always_comb begin
    clr_mask = (bus_wr && bus_addr == A_STAT) ? bus_wdata[FIRST_CH +: NCH] : '0;
    status_d = (status_q & ~clr_mask) | (hit & ien_q);
    ien_d    = (bus_wr && bus_addr == A_IEN) ? bus_wdata[FIRST_CH +: NCH] : ien_q;
    snap_d   = snap_q;
    for (int r = 0; r < NCH; r++) begin
      if (snap_pair(r) && bus_rd && in_cnt && idx == IW'(r) && ctrl_q[r][CB_SNAP])
        snap_d = cnt_q[leader_of(r)];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      ien_q    <= '0;
      snap_q   <= '0;
    end else begin
      status_q <= status_d;
      ien_q    <= ien_d;
      snap_q   <= snap_d;
    end
  end

  assign irq = |status_q;

  always_comb begin
    bus_rdata = '0;
    if (in_cnt) bus_rdata = cnt_q[idx];
    else if (in_ctl) bus_rdata = CW'(ctrl_q[idx]);
    else if (in_mat) bus_rdata = g_match_rd(idx);
    else if (bus_addr == A_STAT) bus_rdata = CW'(status_q) << FIRST_CH;
    else if (bus_addr == A_IEN) bus_rdata = CW'(ien_q) << FIRST_CH;
    else if (bus_addr == A_SNAP) bus_rdata = snap_q;
  end

  logic [CW-1:0] match_rd [NCH];
  for (genvar r = 0; r < NCH; r++) begin : g_mrd
    assign match_rd[r] = g_ch[r].u_ch.match_q;
  end

  function automatic logic [CW-1:0] g_match_rd(input logic [IW-1:0] i);
    return match_rd[i];
  endfunction
endmodule

// File: rtl/tmx_match_timer_chk.sv
module tmx_match_timer_chk
  import tmx_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            bus_wr,
  input logic            bus_rd,
  input logic [AW-1:0]   bus_addr,
  input logic [CW-1:0]   bus_wdata,
  input logic [CW-1:0]   cnt4,
  input logic [CW-1:0]   cnt5,
  input logic [CW-1:0]   cnt8,
  input logic [CTLW-1:0] ctrl5,
  input logic [CTLW-1:0] ctrl8,
  input logic [CTLW-1:0] ctrl9,
  input logic [NCH-1:0]  hit,
  input logic [NCH-1:0]  status_q,
  input logic [NCH-1:0]  ien_q,
  input logic [CW-1:0]   snap_q
);
  // R4: a counter write wins over a tick in the same cycle
  a_r4_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == 8'h40 |=> cnt4 == $past(bus_wdata));

  // R5: a follower tracking its leader keeps its own counter still
  a_r5_follower_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl5[CB_OWN] && !(bus_wr && bus_addr == 8'h44) && !hit[1] |=> $stable(cnt5));

  // R3: forced stop on a wide channel
  a_r3_forced_stop: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl8[CB_FSTOP] && !(bus_wr && bus_addr == 8'h50) && !hit[4] |=> $stable(cnt8));

  // R9: reading counter 9 with capture enabled latches counter 8
  a_r9_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr == 8'h54 && ctrl9[CB_SNAP] |=> snap_q == $past(cnt8));

  for (genvar k = 0; k < NCH; k++) begin : g_stat
    // R11: write-one-to-clear
    a_r11_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && bus_addr == A_STAT && bus_wdata[FIRST_CH + k] && !hit[k] |=> !status_q[k]);
    // R6: status rises only from an enabled match
    a_r6_enabled_match: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_q[k]) |-> $past(hit[k] && ien_q[k]));
  end
endmodule

bind tmx_match_timer tmx_match_timer_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .cnt4      (cnt_q[0]),
  .cnt5      (cnt_q[1]),
  .cnt8      (cnt_q[4]),
  .ctrl5     (ctrl_q[1]),
  .ctrl8     (ctrl_q[4]),
  .ctrl9     (ctrl_q[5]),
  .hit       (hit),
  .status_q  (status_q),
  .ien_q     (ien_q),
  .snap_q    (snap_q)
);

// File: tb/tb_tmx_match_timer.sv
module tb_tmx_match_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [4:0]  tick_en = '0;
  logic        irq;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  tmx_match_timer dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_en(tick_en), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic pulse(input logic [4:0] m, input int n);
    @(negedge clk);
    tick_en = m;
    repeat (n) @(negedge clk);
    tick_en = '0;
  endtask

  task automatic t_reset;
    check("R1 irq", {31'b0, irq}, 0);
    rd_chk("R1 cnt4", 8'h40, 0);
    rd_chk("R1 match11", 8'h9C, 0);
    rd_chk("R1 ctrl8", 8'hD0, 0);
    rd_chk("R1 status", 8'h14, 0);
    rd_chk("R1 snapshot", 8'h20, 0);
  endtask

  task automatic t_clock_select;
    wr(8'hC0, 32'h1);
    pulse(5'b00001, 5);
    rd_chk("R2 code1 counts", 8'h40, 5);
    pulse(5'b11110, 3);
    rd_chk("R2 other ticks ignored", 8'h40, 5);
    wr(8'hC0, 32'h6);
    pulse(5'b11111, 3);
    rd_chk("R2 code6 stopped", 8'h40, 5);
    wr(8'hC0, 32'h4);
    pulse(5'b01000, 2);
    rd_chk("R2 code4 uses tick3", 8'h40, 7);
  endtask

  task automatic t_force_stop;
    wr(8'hD0, 32'h101);
    pulse(5'b00001, 4);
    rd_chk("R3 bit8 stops ch8", 8'h50, 0);
    wr(8'hD0, 32'h001);
    pulse(5'b00001, 4);
    rd_chk("R3 bit8 clear runs", 8'h50, 4);
  endtask

  task automatic t_write_priority;
    wr(8'hC0, 32'h1);
    @(negedge clk);
    tick_en = 5'b00001; bus_wr = 1'b1; bus_addr = 8'h40; bus_wdata = 100;
    @(negedge clk);
    bus_wr = 1'b0; tick_en = '0;
    rd_chk("R4 write beats tick", 8'h40, 100);
    pulse(5'b00001, 1);
    rd_chk("R4 counts after write", 8'h40, 101);
  endtask

  task automatic t_group_and_irq;
    wr(8'hC4, 32'h01);
    wr(8'h40, 0);
    wr(8'h44, 0);
    wr(8'h84, 3);
    wr(8'h1C, 32'h220);
    pulse(5'b00001, 3);
    rd_chk("R5 follower status", 8'h14, 32'h20);
    rd_chk("R5 follower counter held", 8'h44, 0);
    check("R6 irq high", {31'b0, irq}, 1);
    wr(8'hD4, 32'h81);
    wr(8'h54, 0);
    wr(8'h94, 2);
    pulse(5'b00001, 2);
    rd_chk("R6 own-counter match", 8'h14, 32'h220);
    wr(8'h14, 32'h20);
    rd_chk("R11 bit5 cleared", 8'h14, 32'h200);
    check("R11 irq held by bit9", {31'b0, irq}, 1);
    wr(8'h14, 32'h200);
    check("R11 irq low when clear", {31'b0, irq}, 0);
    wr(8'hCC, 32'h81);
    wr(8'h4C, 0);
    wr(8'h8C, 1);
    pulse(5'b00001, 1);
    rd_chk("R6 disabled match silent", 8'h14, 0);
  endtask

  task automatic t_reset_on_match;
    wr(8'hD8, 32'h09);
    wr(8'h58, 0);
    wr(8'h98, 4);
    wr(8'h1C, 32'h400);
    pulse(5'b00001, 4);
    rd_chk("R7 counter cleared", 8'h58, 0);
    rd_chk("R7 status set", 8'h14, 32'h400);
    wr(8'h14, 32'h400);
  endtask

  task automatic t_rearm;
    wr(8'hD0, 32'h49);
    wr(8'h50, 0);
    wr(8'h90, 2);
    wr(8'h1C, 32'h110);
    pulse(5'b00001, 2);
    rd_chk("R8 periodic first", 8'h14, 32'h100);
    wr(8'h14, 32'h100);
    pulse(5'b00001, 2);
    rd_chk("R8 periodic again", 8'h14, 32'h100);
    wr(8'h14, 32'h100);
    wr(8'hD0, 32'h0);
    wr(8'hC0, 32'h09);
    wr(8'h40, 0);
    wr(8'h80, 2);
    pulse(5'b00001, 2);
    rd_chk("R8 one-shot first", 8'h14, 32'h10);
    wr(8'h14, 32'h10);
    pulse(5'b00001, 2);
    rd_chk("R8 one-shot disarmed", 8'h14, 0);
    rd_chk("R8 counter passes match", 8'h40, 2);
  endtask

  task automatic t_snapshot;
    logic [31:0] v;
    wr(8'hDC, 32'h200);
    wr(8'h58, 32'h1234);
    rd(8'h5C, v);
    rd_chk("R9 ch11 snapshot", 8'h20, 32'h1234);
    wr(8'hD4, 32'h81);
    wr(8'h50, 32'h55);
    rd(8'h54, v);
    rd_chk("R9 no capture without bit9", 8'h20, 32'h1234);
    wr(8'hD4, 32'h281);
    rd(8'h54, v);
    rd_chk("R9 ch9 snapshot", 8'h20, 32'h55);
  endtask

  task automatic t_masks;
    wr(8'hC4, 32'hFFFF_FFFF);
    rd_chk("R10 narrow ctrl", 8'hC4, 32'hFF);
    wr(8'hD4, 32'hFFFF_FFFF);
    rd_chk("R10 wide ctrl", 8'hD4, 32'h3FF);
    wr(8'h1C, 32'hFFFF_FFFF);
    rd_chk("R12 enable bits 4-11", 8'h1C, 32'hFF0);
    wr(8'h9C, 32'hCAFE);
    rd_chk("R12 match11 offset", 8'h9C, 32'hCAFE);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_clock_select;
    t_force_stop;
    t_write_priority;
    t_group_and_irq;
    t_reset_on_match;
    t_rearm;
    t_snapshot;
    t_masks;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule